// File: doc/BRIEF.md
# Serial Controller Register Front-End with Receive FIFO

This block is the register-facing half of an asynchronous serial controller that has a receive FIFO. A byte-wide bus reads and writes the registers for mode, control, status, FIFO control and port. Bytes written to the transmit data register leave at once on a single-byte output stream. Bytes arriving on the receive stream are queued in a 16-entry FIFO. Bit-level framing, baud generation and modem lines belong to a separate serialiser and are not part of this block.

Each status flag is cleared by writing a zero to its bit position. Writing a one leaves the flag as it was. The receive-full flag follows a programmable fill threshold both when the FIFO fills and when it drains. The receive interrupt comes from that flag. The transmit interrupt line follows the interrupt-enable bit most recently written to the control register. A status read while the transmitter is enabled sets both transmit-empty flags again.

Register reads return data combinationally from `bus_addr`. The side effects of a read (popping the FIFO, setting the flags again) take place at the clock edge that ends a cycle with `bus_rd` high.

Top module: `uart_regfront`

## Requirements
- R1: The receive FIFO holds 16 bytes and returns them in arrival order. Its head and tail indices wrap past entry 15. A byte that arrives while 16 are held is discarded.
- R2: A receive byte is stored only if control bit 4 (receive enable) is 1. Otherwise it is ignored.
- R3: Reset leaves control at 0x20, mode, port and FIFO control at 0x00, and status at 0x60. Both interrupt lines and `tx_valid` are low after reset.
- R4: The status register (offset 0x10) has these fields: bit 6 transmit-end, bit 5 transmit-empty, bit 4 break, bit 1 receive-full, bit 0 data-ready. A status write clears each of these flags whose written bit is 0 and leaves the flag unchanged where the bit is 1.
- R5: FIFO control (0x18) bits 7:6 select a threshold: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14. Receive-full sets when a stored byte brings the count to the threshold or above. It clears when a FIFO read leaves the count below the threshold.
- R6: `rx_irq` rises when receive-full sets while control bit 6 is 1. It falls on a control write with bit 6 at 0. It also falls on a status write with bit 1 or bit 0 at 0.
- R7: Each control write (0x08) copies written bit 7 onto `tx_irq`.
- R8: A control write with bit 5 (transmit enable) at 0 sets transmit-end.
- R9: A write to 0x0C clears transmit-empty and drives the byte on `tx_data` with `tx_valid` high for exactly the next cycle. A status read sets transmit-empty and transmit-end only when control bit 5 is 1, and the read returns the flags as they stood before this.
- R10: Writing FIFO control with bit 1 set empties the FIFO. A read of 0x14 while the FIFO is empty returns 0x00.
- R11: Writes are masked: mode (0x00) keeps bits under 0x7B, control keeps bits under 0xFA, port (0x20) keeps bits under 0xF3. The stored values read back.
- R12: A one-cycle pulse on `rx_break` sets the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tx_valid | output | 1 | One-cycle pulse: transmit byte available |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |
| rx_break | input | 1 | Break-detected pulse |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The mask table writes all-ones, all-masked and mixed patterns to each masked register. This separates the bits that are kept from the bits that are dropped. The FIFO is run at thresholds 4, 1 and 14. It is filled past capacity and drained across the threshold boundary. This separates "reaches threshold" from "exceeds threshold" and shows that the seventeenth byte is dropped. Status writes use masks with single zeros and with several zeros, and are done with the transmitter both enabled and disabled. This separates clearing by a zero, holding by a one, and setting again on a status read.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_TXD  = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_RXD  = 8'h14;
  localparam logic [7:0] OFS_FCTL = 8'h18;
  localparam logic [7:0] OFS_PORT = 8'h20;

  localparam logic [7:0] MASK_MODE = 8'h7B;
  localparam logic [7:0] MASK_CTRL = 8'hFA;
  localparam logic [7:0] MASK_PORT = 8'hF3;
  localparam logic [7:0] CTRL_RST  = 8'h20;

  localparam int CB_RXEN = 4;
  localparam int CB_TXEN = 5;
  localparam int CB_RIE  = 6;
  localparam int CB_TIE  = 7;
  localparam int FB_FLUSH = 1;

  localparam int SB_TEND = 6;
  localparam int SB_TDE  = 5;
  localparam int SB_BRK  = 4;
  localparam int SB_RDF  = 1;
  localparam int SB_DR   = 0;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } stat_flags_t;

  function automatic logic [7:0] pack_status(input stat_flags_t f);
    logic [7:0] r;
    r = '0;
    r[SB_TEND] = f.tend;
    r[SB_TDE]  = f.tde;
    r[SB_BRK]  = f.brk;
    r[SB_RDF]  = f.rdf;
    r[SB_DR]   = f.dr;
    return r;
  endfunction

  // flags whose bit is written as zero are selected for clearing
  function automatic stat_flags_t zero_bits(input logic [7:0] w);
    stat_flags_t c;
    c.tend = ~w[SB_TEND];
    c.tde  = ~w[SB_TDE];
    c.brk  = ~w[SB_BRK];
    c.rdf  = ~w[SB_RDF];
    c.dr   = ~w[SB_DR];
    return c;
  endfunction

  function automatic logic [7:0] trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd8;
      default: return 8'd14;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH+1)-1:0] count_next,
  output logic             push_acc,
  output logic             pop_acc
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_acc = push && !flush && (count < CNT_W'(DEPTH));
  assign pop_acc  = pop && !flush && (count != '0);
  assign rd_data  = (count != '0) ? mem[tail_q] : '0;

  always_comb begin
    count_next = count;
    if (flush) begin
      count_next = '0;
    end else begin
      if (push_acc) count_next = count_next + 1'b1;
      if (pop_acc)  count_next = count_next - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[head_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      count  <= '0;
    end else begin
      count <= count_next;
      if (flush) begin
        head_q <= '0;
        tail_q <= '0;
      end else begin
        if (push_acc) head_q <= bump(head_q);
        if (pop_acc)  tail_q <= bump(tail_q);
      end
    end
  end

  // R1
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && push && !pop && !flush) |=> count == CNT_W'(DEPTH));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
  import uart_regfront_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  stat_flags_t set_i,
  input  stat_flags_t clr_i,
  input  logic        irq_set,
  input  logic        irq_clr,
  output stat_flags_t flags,
  output logic        rx_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags  <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
      rx_irq <= 1'b0;
    end else begin
      flags  <= (flags | set_i) & ~clr_i;
      rx_irq <= (rx_irq | irq_set) & ~irq_clr;
    end
  end

  // R4
  tde_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i.tde |=> !flags.tde);

  // R4
  rdf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i.rdf |=> !flags.rdf);

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !rx_irq);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_break,
  output logic       rx_irq,
  output logic       tx_irq
);
  localparam int CNT_W = $clog2(RX_DEPTH + 1);

  logic [7:0] mode_q, ctrl_q, fctl_q, port_q;

  logic wr_mode, wr_ctrl, wr_txd, wr_stat, wr_fctl, wr_port;
  logic rd_stat, rd_rxd;
  assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_txd  = bus_wr && (bus_addr == OFS_TXD);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign wr_fctl = bus_wr && (bus_addr == OFS_FCTL);
  assign wr_port = bus_wr && (bus_addr == OFS_PORT);
  assign rd_stat = bus_rd && (bus_addr == OFS_STAT);
  assign rd_rxd  = bus_rd && (bus_addr == OFS_RXD);

  // named events for the assertions
  logic rx_push, rx_flush, rearm_tx;
  assign rx_push  = rx_valid && ctrl_q[CB_RXEN];
  assign rx_flush = wr_fctl && bus_wdata[FB_FLUSH];
  assign rearm_tx = rd_stat && ctrl_q[CB_TXEN];

  logic [7:0]       fifo_rd_data;
  logic [CNT_W-1:0] rx_count, rx_count_next, trig;
  logic             push_acc, pop_acc;

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (rx_push),
    .push_data  (rx_data),
    .pop        (rd_rxd),
    .flush      (rx_flush),
    .rd_data    (fifo_rd_data),
    .count      (rx_count),
    .count_next (rx_count_next),
    .push_acc   (push_acc),
    .pop_acc    (pop_acc)
  );

  assign trig = CNT_W'(trig_level(fctl_q[7:6]));

  logic rdf_rise, rdf_fall;
  assign rdf_rise = push_acc && (rx_count_next >= trig);
  assign rdf_fall = pop_acc && (rx_count_next < trig);

  stat_flags_t fl_set, fl_clr, flags, wclr;
  logic        irq_set, irq_clr;

  always_comb begin
    wclr = wr_stat ? zero_bits(bus_wdata) : '0;
    fl_set.tend = (wr_ctrl && !bus_wdata[CB_TXEN]) || rearm_tx;
    fl_set.tde  = rearm_tx;
    fl_set.brk  = rx_break;
    fl_set.rdf  = rdf_rise;
    fl_set.dr   = 1'b0;
    fl_clr      = wclr;
    fl_clr.tde  = wclr.tde || wr_txd;
    fl_clr.rdf  = wclr.rdf || rdf_fall;
    irq_set = rdf_rise && ctrl_q[CB_RIE];
    irq_clr = (wr_ctrl && !bus_wdata[CB_RIE]) || wclr.rdf || wclr.dr;
  end

  uart_stat_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (fl_set),
    .clr_i   (fl_clr),
    .irq_set (irq_set),
    .irq_clr (irq_clr),
    .flags   (flags),
    .rx_irq  (rx_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ctrl_q   <= CTRL_RST;
      fctl_q   <= '0;
      port_q   <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_irq   <= 1'b0;
    end else begin
      tx_valid <= wr_txd;
      if (wr_txd)  tx_data <= bus_wdata;
      if (wr_mode) mode_q  <= bus_wdata & MASK_MODE;
      if (wr_ctrl) begin
        ctrl_q <= bus_wdata & MASK_CTRL;
        tx_irq <= bus_wdata[CB_TIE];
      end
      if (wr_fctl) fctl_q <= bus_wdata;
      if (wr_port) port_q <= bus_wdata & MASK_PORT;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = mode_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_TXD:  bus_rdata = tx_data;
      OFS_STAT: bus_rdata = pack_status(flags);
      OFS_RXD:  bus_rdata = fifo_rd_data;
      OFS_FCTL: bus_rdata = fctl_q;
      OFS_PORT: bus_rdata = port_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R2
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ctrl_q[CB_RXEN] && !rd_rxd && !wr_fctl) |=> $stable(rx_count));

  // R7
  tx_irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> tx_irq == $past(bus_wdata[CB_TIE]));

  // R9
  tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> (tx_valid && tx_data == $past(bus_wdata) && !flags.tde));

  // R5
  rdf_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && !wr_stat && (rx_count_next >= trig)) |=> flags.rdf);
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_break = 1'b0;
  logic       rx_irq, tx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  // {address, written value, expected read-back}
  localparam logic [23:0] MASK_VEC [8] = '{
    {8'h00, 8'hFF, 8'h7B}, {8'h00, 8'h84, 8'h00},
    {8'h08, 8'hFF, 8'hFA}, {8'h08, 8'h05, 8'h00},
    {8'h20, 8'hFF, 8'hF3}, {8'h20, 8'h0C, 8'h00},
    {8'h20, 8'hA5, 8'hA1}, {8'h08, 8'h30, 8'h30}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    bus_read(8'h10, r); check("R3 status", r, 8'h60);
    bus_read(8'h08, r); check("R3 control", r, 8'h20);
    bus_read(8'h18, r); check("R3 fifo ctrl", r, 8'h00);
    check("R3 irq lines", {6'b0, rx_irq, tx_irq}, 8'h00);
    check("R3 tx_valid", {7'b0, tx_valid}, 8'h00);

    // R11 write masks, table driven
    foreach (MASK_VEC[i]) begin
      bus_write(MASK_VEC[i][23:16], MASK_VEC[i][15:8]);
      bus_read(MASK_VEC[i][23:16], r);
      check("R11 mask readback", r, MASK_VEC[i][7:0]);
    end

    // R9 transmit hand-off and re-arm
    bus_write(8'h0C, 8'h5A);
    check("R9 tx_valid pulse", {7'b0, tx_valid}, 8'h01);
    check("R9 tx_data", tx_data, 8'h5A);
    @(negedge clk);
    check("R9 tx_valid one cycle", {7'b0, tx_valid}, 8'h00);
    bus_read(8'h10, r); check("R9 tde cleared", r, 8'h40);
    bus_read(8'h10, r); check("R9 re-armed", r, 8'h60);

    // R4 clear by zero
    bus_write(8'h10, 8'hFF);
    bus_read(8'h10, r); check("R4 ones keep", r, 8'h60);
    bus_write(8'h10, 8'h9F);
    bus_read(8'h10, r); check("R4 zeros clear", r, 8'h00);
    bus_read(8'h10, r); check("R9 re-arm after clear", r, 8'h60);

    // R12 break
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    bus_read(8'h10, r); check("R12 break set", r, 8'h70);
    bus_write(8'h10, 8'hEF);
    bus_read(8'h10, r); check("R4 break cleared", r, 8'h60);

    // R2 receive disabled
    bus_write(8'h08, 8'h20);
    rx_send(8'h99);
    bus_read(8'h14, r); check("R2 byte ignored", r, 8'h00);
    bus_read(8'h10, r); check("R2 no rdf", r, 8'h60);

    // R5/R6 threshold 4 with interrupt
    bus_write(8'h18, 8'h40);
    bus_write(8'h08, 8'h70);
    rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
    check("R6 irq below threshold", {7'b0, rx_irq}, 8'h00);
    bus_read(8'h10, r); check("R5 below threshold", r, 8'h60);
    rx_send(8'h44);
    check("R6 irq at threshold", {7'b0, rx_irq}, 8'h01);
    bus_read(8'h10, r); check("R5 at threshold", r, 8'h62);
    bus_read(8'h14, r); check("R1 first byte", r, 8'h11);
    bus_read(8'h10, r); check("R5 drained below", r, 8'h60);
    check("R6 irq held over pop", {7'b0, rx_irq}, 8'h01);
    bus_write(8'h10, 8'hFD);
    check("R6 irq cleared by status", {7'b0, rx_irq}, 8'h00);
    bus_read(8'h14, r); check("R1 order 2", r, 8'h22);
    bus_read(8'h14, r); check("R1 order 3", r, 8'h33);
    bus_read(8'h14, r); check("R1 order 4", r, 8'h44);
    bus_read(8'h14, r); check("R10 empty read", r, 8'h00);

    // R6 control clear, R10 flush
    bus_write(8'h18, 8'h00);
    rx_send(8'h55);
    check("R6 irq threshold 1", {7'b0, rx_irq}, 8'h01);
    bus_write(8'h08, 8'h30);
    check("R6 irq cleared by control", {7'b0, rx_irq}, 8'h00);
    bus_write(8'h18, 8'h02);
    bus_read(8'h14, r); check("R10 flushed", r, 8'h00);
    bus_write(8'h10, 8'hFD);

    // R1 overflow and R5 threshold 14
    bus_write(8'h18, 8'hC0);
    for (int i = 1; i <= 17; i++) rx_send(8'(i));
    bus_read(8'h10, r); check("R5 full", r, 8'h62);
    bus_read(8'h14, r); check("R1 pop 1", r, 8'h01);
    bus_read(8'h14, r); check("R1 pop 2", r, 8'h02);
    bus_read(8'h10, r); check("R5 count 14 keeps", r, 8'h62);
    bus_read(8'h14, r); check("R1 pop 3", r, 8'h03);
    bus_read(8'h10, r); check("R5 count 13 clears", r, 8'h60);
    for (int i = 4; i <= 16; i++) begin
      bus_read(8'h14, r); check("R1 drain order", r, 8'(i));
    end
    bus_read(8'h14, r); check("R1 17th dropped", r, 8'h00);
    rx_send(8'hA0); rx_send(8'hA1); rx_send(8'hA2);
    for (int i = 0; i < 3; i++) begin
      bus_read(8'h14, r); check("R1 after wrap", r, 8'hA0 + 8'(i));
    end

    // R7 transmit interrupt line
    bus_write(8'h08, 8'hB0);
    check("R7 tx_irq high", {7'b0, tx_irq}, 8'h01);
    bus_write(8'h08, 8'h30);
    check("R7 tx_irq low", {7'b0, tx_irq}, 8'h00);

    // R8 transmitter disable, no re-arm
    bus_write(8'h10, 8'h9F);
    bus_write(8'h08, 8'h10);
    bus_read(8'h10, r); check("R8 tend set", r, 8'h40);
    bus_read(8'h10, r); check("R9 no re-arm when disabled", r, 8'h40);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule